// File: doc/BRIEF.md
# Streaming RGB565 to Luma Converter

This block takes a stream of 16-bit RGB565 pixels and turns each one into an 8-bit grayscale intensity. It applies the usual luminance weighting of roughly 0.30 red, 0.59 green and 0.11 blue. Each colour channel is first widened to 8 bits by repeating its top bits. The widened channel is multiplied by a fixed 8-bit fractional coefficient: red uses 77, green 151 and blue 28, which add up to 256. An explicitly pipelined two-level adder tree then sums the three terms, and the result is the upper byte of the sum.

A valid flag comes in with every pixel. So do three start markers, for the first pixel of a row, of a frame and of a whole sequence. These markers pass through a delay line as long as the datapath, so they come out on the same cycle as the luma of their own pixel. The pipeline moves forward on every clock, whether or not the valid flag is set. The design has no backpressure.

Top module: `rgbl_top`

## Requirements
- R1: The pixel input holds blue in bits [4:0], green in bits [10:5] and red in bits [15:11], all unsigned.
- R2: The output luma equals floor((77*R8 + 151*G8 + 28*B8) / 256). Here R8 = {R, R[4:2]}, G8 = {G, G[5:4]} and B8 = {B, B[4:2]}.
- R3: An all-zero pixel gives luma 0 and an all-ones pixel gives luma 255, so full scale is reached with no overflow.
- R4: The luma of a pixel presented before rising edge k appears on the output right after rising edge k+2, a latency of three clocks.
- R5: The output valid flag equals the input valid flag delayed by exactly three clocks.
- R6: The row, frame and sequence start outputs each equal their input delayed by exactly three clocks. Each one stays aligned with the luma of its own pixel.
- R7: While the active-low synchronous reset is low, the valid and all start outputs read 0 after each clock edge. After reset is released they stay 0 until the first post-reset inputs arrive three clocks later.
- R8: The pipeline advances on every clock. A pixel presented with valid low still produces its luma three clocks later, and a gap in valid does not shift the timing of later pixels.
- R9: Back-to-back pixels on consecutive clocks each produce their own luma. No term of one pixel is summed with a term of a neighbouring pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_pix | input | 16 | RGB565 pixel |
| in_row_start | input | 1 | First pixel of a row |
| in_frame_start | input | 1 | First pixel of a frame |
| in_seq_start | input | 1 | First pixel of a sequence |
| out_valid | output | 1 | Delayed valid flag |
| out_luma | output | 8 | Grayscale intensity |
| out_row_start | output | 1 | Delayed row start |
| out_frame_start | output | 1 | Delayed frame start |
| out_seq_start | output | 1 | Delayed sequence start |

## Verification
The delay and luma assertions rely on the inputs being driven to known values on every clock after reset. The unreset data registers only hold meaningful values once three such clocks have passed, and a small cycle counter after reset keeps each delay check quiet until then. The bench changes inputs only on falling edges and never leaves them undriven, including during gaps where valid is low. Its sequences cover every colour extreme, ramps, pseudo-random pixels and irregular patterns of valid and start flags.

// File: rtl/rgbl_pkg.sv
package rgbl_pkg;
  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;
  localparam int PIX_W   = RED_W + GRN_W + BLU_W;
  localparam int LUMA_W  = 8;
  localparam int COEF_W  = 8;
  localparam int PROD_W  = LUMA_W + COEF_W;
  localparam int SUM_W   = PROD_W + 1;
  localparam int TAG_W   = 4;
  localparam int LATENCY = 3;

  localparam logic [COEF_W-1:0] K_RED = 8'd77;
  localparam logic [COEF_W-1:0] K_GRN = 8'd151;
  localparam logic [COEF_W-1:0] K_BLU = 8'd28;

  // tag bundle carried beside the data
  typedef struct packed {
    logic seq_start;
    logic frame_start;
    logic row_start;
    logic valid;
  } tag_t;

  // Widen a w-bit channel to LUMA_W bits by repeating its MSBs cyclically.
  function automatic logic [LUMA_W-1:0] widen(input logic [LUMA_W-1:0] x, input int w);
    logic [LUMA_W-1:0] r;
    for (int i = 0; i < LUMA_W; i++) begin
      r[i] = x[(w - 1) - ((LUMA_W - 1 - i) % w)];
    end
    return r;
  endfunction

  // Full arithmetic model of one pixel, used by checkers.
  function automatic logic [LUMA_W-1:0] luma_of(input logic [PIX_W-1:0] p);
    logic [LUMA_W-1:0] r8, g8, b8;
    logic [SUM_W-1:0]  s;
    r8 = widen(LUMA_W'(p[PIX_W-1 -: RED_W]), RED_W);
    g8 = widen(LUMA_W'(p[BLU_W +: GRN_W]), GRN_W);
    b8 = widen(LUMA_W'(p[BLU_W-1:0]), BLU_W);
    s  = SUM_W'(r8 * K_RED) + SUM_W'(g8 * K_GRN) + SUM_W'(b8 * K_BLU);
    return s[COEF_W +: LUMA_W];
  endfunction
endpackage

// File: rtl/rgbl_chan_gain.sv
module rgbl_chan_gain
  import rgbl_pkg::*;
#(
  parameter int IN_W = 5,
  parameter logic [COEF_W-1:0] COEF = 8'd77
) (
  input  logic              clk,
  input  logic [IN_W-1:0]   chan,
  output logic [PROD_W-1:0] prod
);
  logic [LUMA_W-1:0] chan8;

  always_comb chan8 = widen(LUMA_W'(chan), IN_W);

  // gain stage register: first of the three pipeline clocks
  always_ff @(posedge clk) begin
    prod <= PROD_W'(chan8 * COEF);
  end
endmodule

// File: rtl/rgbl_add_tree.sv
module rgbl_add_tree
  import rgbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROD_W-1:0] term_r,
  input  logic [PROD_W-1:0] term_g,
  input  logic [PROD_W-1:0] term_b,
  output logic [LUMA_W-1:0] luma
);
  logic [SUM_W-1:0]  sum_rg;
  logic [PROD_W-1:0] term_b_bal;
  logic [SUM_W-1:0]  sum_all;
  logic [SUM_W-1:0]  sum_all_d;

  // level 1: add red and green; blue is delayed to stay with its pixel
  always_ff @(posedge clk) begin
    sum_rg     <= SUM_W'(term_r) + SUM_W'(term_g);
    term_b_bal <= term_b;
  end

  always_comb sum_all = sum_rg + SUM_W'(term_b_bal);

  // level 2: final sum register
  always_ff @(posedge clk) begin
    sum_all_d <= sum_all;
  end

  assign luma = sum_all_d[COEF_W +: LUMA_W];

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)        warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (sum_all_d < SUM_W'(17'd65536)));
endmodule

// File: rtl/rgbl_tag_pipe.sv
module rgbl_tag_pipe
  import rgbl_pkg::*;
#(
  parameter int DEPTH = LATENCY,
  parameter int W = TAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tag_in,
  output logic [W-1:0] tag_out
);
  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)     stage[s] <= '0;
        else if (s == 0) stage[s] <= tag_in;
        else            stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign tag_out = stage[DEPTH-1];

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R5 R6
  tag_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (tag_out == $past(tag_in, 3)));

  // R7
  tag_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |=> (tag_out == '0));
endmodule

// File: rtl/rgbl_top.sv
module rgbl_top
  import rgbl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_pix,
  input  logic        in_row_start,
  input  logic        in_frame_start,
  input  logic        in_seq_start,
  output logic        out_valid,
  output logic [7:0]  out_luma,
  output logic        out_row_start,
  output logic        out_frame_start,
  output logic        out_seq_start
);
  logic [RED_W-1:0]  red;
  logic [GRN_W-1:0]  grn;
  logic [BLU_W-1:0]  blu;
  logic [PROD_W-1:0] p_red, p_grn, p_blu;
  tag_t              tag_i, tag_o;

  assign red = in_pix[PIX_W-1 -: RED_W];
  assign grn = in_pix[BLU_W +: GRN_W];
  assign blu = in_pix[BLU_W-1:0];

  rgbl_chan_gain #(.IN_W(RED_W), .COEF(K_RED)) u_gain_r (.clk(clk), .chan(red), .prod(p_red));
  rgbl_chan_gain #(.IN_W(GRN_W), .COEF(K_GRN)) u_gain_g (.clk(clk), .chan(grn), .prod(p_grn));
  rgbl_chan_gain #(.IN_W(BLU_W), .COEF(K_BLU)) u_gain_b (.clk(clk), .chan(blu), .prod(p_blu));

  rgbl_add_tree u_tree (
    .clk(clk), .rst_n(rst_n),
    .term_r(p_red), .term_g(p_grn), .term_b(p_blu),
    .luma(out_luma)
  );

  always_comb begin
    tag_i.valid       = in_valid;
    tag_i.row_start   = in_row_start;
    tag_i.frame_start = in_frame_start;
    tag_i.seq_start   = in_seq_start;
  end

  rgbl_tag_pipe #(.DEPTH(LATENCY), .W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .tag_in(tag_i), .tag_out(tag_o)
  );

  assign out_valid       = tag_o.valid;
  assign out_row_start   = tag_o.row_start;
  assign out_frame_start = tag_o.frame_start;
  assign out_seq_start   = tag_o.seq_start;

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R2 R4 R8 R9
  luma_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_luma == $past(luma_of(in_pix), 3)));

  // R6
  row_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_row_start == $past(in_row_start, 3)));
endmodule

// File: tb/sim_rgbl_top.sv
module sim_rgbl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_pix = '0;
  logic        in_row_start = 1'b0;
  logic        in_frame_start = 1'b0;
  logic        in_seq_start = 1'b0;
  logic        out_valid;
  logic [7:0]  out_luma;
  logic        out_row_start, out_frame_start, out_seq_start;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rgbl_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_row_start(in_row_start), .in_frame_start(in_frame_start), .in_seq_start(in_seq_start),
    .out_valid(out_valid), .out_luma(out_luma), .out_row_start(out_row_start),
    .out_frame_start(out_frame_start), .out_seq_start(out_seq_start)
  );

  // stimulus arrays: pixel and flags {seq,frame,row,valid}
  logic [15:0] s_pix [64];
  logic [3:0]  s_tag [64];

  // independent reference: shift-or expansion then integer weighting
  function automatic int ref_luma(input logic [15:0] p);
    int r, g, b, r8, g8, b8;
    r = int'(p >> 11) & 31;
    g = int'(p >> 5) & 63;
    b = int'(p) & 31;
    r8 = (r << 3) | (r >> 2);
    g8 = (g << 2) | (g >> 4);
    b8 = (b << 3) | (b >> 2);
    return (r8 * 77 + g8 * 151 + b8 * 28) / 256;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Streams n entries, checking each result three falling edges after driving.
  task automatic run_stream(input int n, input string req);
    for (int j = 0; j < n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        check(req, "luma", int'(out_luma), ref_luma(s_pix[j-3]));
        check(req, "tags", int'({out_seq_start, out_frame_start, out_row_start, out_valid}),
              int'(s_tag[j-3]));
      end
      if (j < n) begin
        in_pix = s_pix[j];
        {in_seq_start, in_frame_start, in_row_start, in_valid} = s_tag[j];
      end else begin
        in_pix = '0;
        {in_seq_start, in_frame_start, in_row_start, in_valid} = 4'b0;
      end
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    in_valid = 1'b1; in_row_start = 1'b1; in_frame_start = 1'b1; in_seq_start = 1'b1;
    repeat (4) @(negedge clk);
    // R7: flags held at zero during reset
    check("R7", "tags in reset", int'({out_seq_start, out_frame_start, out_row_start, out_valid}), 0);
    in_valid = 1'b0; in_row_start = 1'b0; in_frame_start = 1'b0; in_seq_start = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", "tags after release", int'({out_seq_start, out_frame_start, out_row_start, out_valid}), 0);
    end
  endtask

  task automatic test_extremes();
    s_pix[0] = 16'h0000; s_pix[1] = 16'hFFFF; s_pix[2] = 16'hF800;
    s_pix[3] = 16'h07E0; s_pix[4] = 16'h001F; s_pix[5] = 16'h8410;
    for (int i = 0; i < 6; i++) s_tag[i] = 4'b0001;
    run_stream(6, "R1_R2");
    // R3: explicit full-scale points
    check("R3", "black ref", ref_luma(16'h0000), 0);
    check("R3", "white ref", ref_luma(16'hFFFF), 255);
  endtask

  task automatic test_ramp();
    for (int i = 0; i < 32; i++) begin
      s_pix[i] = 16'({5'(i), 6'(2*i), 5'(31-i)});
      s_tag[i] = 4'b0001;
    end
    run_stream(32, "R9");
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 20; i++) begin
      s_pix[i] = 16'(16'h1357 * (i + 3));
      s_tag[i] = {3'b000, 1'((i % 3) != 1)};
    end
    run_stream(20, "R8");
  endtask

  task automatic test_flags();
    for (int i = 0; i < 24; i++) begin
      s_pix[i] = 16'(16'hA5C3 ^ (i * 16'h0913));
      s_tag[i] = {1'(i == 0), 1'(i == 0 || i == 12), 1'(i % 6 == 0), 1'(i != 5)};
    end
    run_stream(24, "R6");
  endtask

  task automatic test_latency();
    // R4: single pixel, output must appear after exactly three edges
    @(negedge clk);
    in_pix = 16'hFFFF; in_valid = 1'b1;
    @(negedge clk);
    in_pix = 16'h0000; in_valid = 1'b0;
    @(negedge clk);
    check("R4", "not yet (2 edges)", int'(out_valid), 0);
    @(negedge clk);
    check("R4", "luma at 3 edges", int'(out_luma), 255);
    check("R5", "valid at 3 edges", int'(out_valid), 1);
    @(negedge clk);
    check("R5", "valid drops", int'(out_valid), 0);
    check("R4", "luma follows next pixel", int'(out_luma), 0);
  endtask

  task automatic test_random();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s_pix[i] = lfsr;
      s_tag[i] = {lfsr[3] & lfsr[7], lfsr[5] & lfsr[1], lfsr[2], lfsr[0] | lfsr[9]};
    end
    run_stream(64, "R2");
  endtask

  task automatic test_mid_reset();
    @(negedge clk);
    in_valid = 1'b1; in_row_start = 1'b1; in_pix = 16'h1234;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R7: reset clears the flags still in flight
    check("R7", "mid-stream reset", int'({out_seq_start, out_frame_start, out_row_start, out_valid}), 0);
    in_valid = 1'b0; in_row_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", "quiet after reset", int'(out_valid), 0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_extremes();
        test_ramp();
        test_gaps();
        test_flags();
        test_latency();
        test_random();
        test_mid_reset();
      end
      begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule